// File: doc/BRIEF.md
# In-Place Exchange Sorter

This block keeps a small bank of unsigned words in internal registers and sorts them into ascending order without any external storage. While the mode input `start_i` is low, a host loads the bank one word per cycle, using a write strobe, an address and a data word. When `start_i` goes high, the controller runs a nested exchange sort over the bank, and then asserts `done_o`.

The outer index `i` walks from the first slot to the next-to-last. At each outer step the word at `i` is latched into a running-minimum register A. The inner index `j` then walks from `i+1` to the last slot. At each inner step the word at `j` is latched into register B. When B is strictly below A, the two slots are exchanged in one cycle, and A takes the smaller value.

Once `done_o` is high, the host reads the sorted words back by address. A read is combinational and is qualified by a read-enable input.

Top module: `exch_sorter`

## Requirements
- R1: After reset, `done_o` is low and every slot of the bank reads back as zero.
- R2: With `start_i` low and the controller idle, a cycle with `wr_init_i` high stores `data_i` into the slot selected by `addr_i`. Slots 0 to DEPTH-1 map directly to addresses 0 to DEPTH-1.
- R3: `data_o` equals the slot selected by `addr_i` in the same cycle while `rd_i` is high, and is zero while `rd_i` is low.
- R4: After a sort, the bank holds the loaded words, permuted into non-decreasing unsigned order from address 0 upwards. For example, 3,2,4,1 becomes 1,2,3,4.
- R5: Words that compare equal are never exchanged. Inputs with duplicate values produce the correctly sorted multiset.
- R6: `done_o` rises when the sort completes and stays high while `start_i` remains high. It falls one clock edge after `start_i` is sampled low.
- R7: `wr_init_i` has no effect while `start_i` is high, whether the sort is running or finished.
- R8: `done_o` first reads high at the clock edge numbered DEPTH + DEPTH*(DEPTH-1) + s, where s is the number of exchanges the algorithm performs. Edge 1 is the first edge that samples `start_i` high in idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | DATA_W | Word to load |
| addr_i | input | ADDR_W | Slot address for load and read |
| wr_init_i | input | 1 | Load strobe (idle, start low) |
| start_i | input | 1 | 0 = load mode, 1 = sort |
| rd_i | input | 1 | Read enable for data_o |
| data_o | output | DATA_W | Selected slot, or zero |
| done_o | output | 1 | Sort finished |

## Verification
The hardest condition to reach is an exchange on the very last inner step of an outer pass, right where the indices wrap. Such an exchange both lengthens the run and decides whether the next pass starts from the right minimum. Random vectors over the full range seldom place the smallest remaining value at the end, so the stimulus adds reversed input, the worked 3,2,4,1 case and narrow-range random words. The narrow-range words also yield many ties. Every run is timed against the exchange count from a bench model, which exposes any missed or extra exchange even when the final order comes out right.

// File: rtl/sorter_pkg.sv
package sorter_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LDA,
    ST_LDB,
    ST_CMP,
    ST_SWP,
    ST_DONE
  } sort_state_e;
endpackage

// File: rtl/sort_regfile.sv
module sort_regfile #(
  parameter int DEPTH  = 4,
  parameter int DATA_W = 8,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ext_we_i,
  input  logic [ADDR_W-1:0] ext_addr_i,
  input  logic [DATA_W-1:0] ext_data_i,
  input  logic              swp_i,
  input  logic [ADDR_W-1:0] idx_a_i,
  input  logic [ADDR_W-1:0] idx_b_i,
  input  logic [DATA_W-1:0] val_a_i,
  input  logic [DATA_W-1:0] val_b_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [DATA_W-1:0] a_data_o,
  output logic [DATA_W-1:0] b_data_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                       mem_q[e] <= '0;
      else if (swp_i && idx_a_i == ADDR_W'(e))           mem_q[e] <= val_a_i;
      else if (swp_i && idx_b_i == ADDR_W'(e))           mem_q[e] <= val_b_i;
      else if (ext_we_i && ext_addr_i == ADDR_W'(e))     mem_q[e] <= ext_data_i;
    end
  end

  assign rd_data_o = mem_q[ext_addr_i];
  assign a_data_o  = mem_q[idx_a_i];
  assign b_data_o  = mem_q[idx_b_i];

  // host loads never collide with an exchange
  assert_write_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_we_i |-> !swp_i);

  // after an exchange the lower slot holds the smaller word
  assert_swap_order_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swp_i |=> (mem_q[$past(idx_a_i)] <= mem_q[$past(idx_b_i)]));
endmodule

// File: rtl/sort_ctrl.sv
module sort_ctrl
  import sorter_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              lt_i,
  output logic              ld_a_o,
  output logic              ld_b_o,
  output logic              swp_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] idx_i_o,
  output logic [ADDR_W-1:0] idx_j_o
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);
  localparam logic [ADDR_W-1:0] ONE  = ADDR_W'(1);

  sort_state_e state_q, state_d;
  logic [ADDR_W-1:0] i_q, j_q;
  logic step;

  assign step = (state_q == ST_CMP && !lt_i) || state_q == ST_SWP;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_LDA;
      ST_LDA:  state_d = ST_LDB;
      ST_LDB:  state_d = ST_CMP;
      ST_CMP, ST_SWP: begin
        if (state_q == ST_CMP && lt_i) state_d = ST_SWP;
        else if (j_q != LAST)          state_d = ST_LDB;
        else if (i_q == LAST - ONE)    state_d = ST_DONE;
        else                           state_d = ST_LDA;
      end
      ST_DONE: if (!start_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      i_q     <= '0;
      j_q     <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && start_i) i_q <= '0;
      if (state_q == ST_LDA)             j_q <= i_q + ONE;
      if (step) begin
        if (j_q == LAST) i_q <= i_q + ONE;
        else             j_q <= j_q + ONE;
      end
    end
  end

  assign ld_a_o  = state_q == ST_LDA;
  assign ld_b_o  = state_q == ST_LDB;
  assign swp_o   = state_q == ST_SWP;
  assign done_o  = state_q == ST_DONE;
  assign busy_o  = state_q != ST_IDLE && state_q != ST_DONE;
  assign idx_i_o = i_q;
  assign idx_j_o = j_q;

  assert_index_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LDB || state_q == ST_CMP || state_q == ST_SWP)
      |-> (i_q < LAST && j_q > i_q && j_q <= LAST));

  assert_done_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && start_i) |=> done_o);

  assert_done_release_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> !done_o);
endmodule

// File: rtl/exch_sorter.sv
module exch_sorter #(
  parameter int DEPTH  = 4,
  parameter int DATA_W = 8,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_init_i,
  input  logic              start_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] data_o,
  output logic              done_o
);
  logic ld_a, ld_b, swp, busy, lt, ext_we;
  logic [ADDR_W-1:0] idx_i, idx_j;
  logic [DATA_W-1:0] a_q, b_q, rd_data, a_data, b_data;

  sort_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i, .rst_ni, .start_i,
    .lt_i    (lt),
    .ld_a_o  (ld_a),
    .ld_b_o  (ld_b),
    .swp_o   (swp),
    .busy_o  (busy),
    .done_o  (done_o),
    .idx_i_o (idx_i),
    .idx_j_o (idx_j)
  );

  assign ext_we = wr_init_i && !start_i && !busy;

  sort_regfile #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_rf (
    .clk_i, .rst_ni,
    .ext_we_i   (ext_we),
    .ext_addr_i (addr_i),
    .ext_data_i (data_i),
    .swp_i      (swp),
    .idx_a_i    (idx_i),
    .idx_b_i    (idx_j),
    .val_a_i    (b_q),
    .val_b_i    (a_q),
    .rd_data_o  (rd_data),
    .a_data_o   (a_data),
    .b_data_o   (b_data)
  );

  // A tracks the running minimum; after an exchange it equals new R[i] = B
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= '0;
      b_q <= '0;
    end else begin
      if (ld_a)     a_q <= a_data;
      else if (swp) a_q <= b_q;
      if (ld_b)     b_q <= b_data;
    end
  end

  assign lt     = b_q < a_q;
  assign data_o = rd_i ? rd_data : '0;

  assert_swap_lower_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swp |-> (b_q < a_q));

  assert_no_tie_swap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swp |-> (b_q != a_q));

  assert_min_after_swap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swp |=> (a_q == $past(b_q)));
endmodule

// File: tb/exch_sorter_test.sv
module exch_sorter_test;
  localparam int K  = 4;
  localparam int W  = 8;
  localparam int AW = 2;
  typedef logic [W-1:0] vec_t [K];

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] data_i = '0;
  logic [AW-1:0] addr_i = '0;
  logic wr_init = 1'b0, start = 1'b0, rd = 1'b0;
  logic [W-1:0] data_o;
  logic done;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  exch_sorter #(.DEPTH(K), .DATA_W(W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .data_i(data_i), .addr_i(addr_i),
    .wr_init_i(wr_init), .start_i(start), .rd_i(rd),
    .data_o(data_o), .done_o(done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    addr_i = AW'(a); data_i = W'(d); wr_init = 1'b1;
    @(negedge clk);
    wr_init = 1'b0;
  endtask

  task automatic rd_word(input int a, output int v);
    @(negedge clk);
    addr_i = AW'(a); rd = 1'b1;
    #2 v = int'(data_o);
    rd = 1'b0;
  endtask

  function automatic void model(input vec_t v, output vec_t r, output int sw);
    logic [W-1:0] a, b;
    r = v; sw = 0;
    for (int i = 0; i < K - 1; i++) begin
      a = r[i];
      for (int j = i + 1; j < K; j++) begin
        b = r[j];
        if (b < a) begin
          r[i] = b; r[j] = a; a = b; sw++;
        end
      end
    end
  endfunction

  task automatic run_sort(input vec_t v, input string tag);
    vec_t exp_v;
    int sw, n, got;
    model(v, exp_v, sw);
    for (int a = 0; a < K; a++) wr(a, int'(v[a]));
    for (int a = 0; a < K; a++) begin
      rd_word(a, got);
      check(got == int'(v[a]), "R2", {tag, " load"}, got, v[a]);
    end
    @(negedge clk);
    start = 1'b1;
    n = 0;
    while (n < 200) begin
      @(posedge clk); n++;
      #1 if (done) break;
    end
    // R8 latency = K + K(K-1) + exchanges
    check(n == K + K * (K - 1) + sw, "R8", {tag, " latency"}, n, K + K * (K - 1) + sw);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      check(done == 1'b1, "R6", {tag, " done held"}, done, 1);
    end
    for (int a = 0; a < K; a++) begin
      rd_word(a, got);
      check(got == int'(exp_v[a]), "R4", {tag, " sorted"}, got, exp_v[a]);
    end
    // R7: load strobe with start high must be ignored
    wr(0, int'(~exp_v[0]));
    rd_word(0, got);
    check(got == int'(exp_v[0]), "R7", {tag, " write ignored"}, got, exp_v[0]);
    @(negedge clk);
    start = 1'b0;
    @(posedge clk); #1;
    check(done == 1'b0, "R6", {tag, " done release"}, done, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : stim
    vec_t v;
    int got, seed;
    seed = $urandom(32'd545);
    repeat (3) @(negedge clk);
    // R1 reset state
    check(done == 1'b0, "R1", "done after reset", done, 0);
    check(data_o == '0, "R3", "data_o with rd low", data_o, 0);
    rst_n = 1'b1;
    for (int a = 0; a < K; a++) begin
      rd_word(a, got);
      check(got == 0, "R1", "slot cleared", got, 0);
    end
    // R2/R3
    wr(2, 8'hA5);
    rd_word(2, got);
    check(got == 8'hA5, "R2", "single load", got, 8'hA5);
    @(negedge clk); addr_i = 2'd2; rd = 1'b0;
    #2 check(data_o == '0, "R3", "read gated", data_o, 0);

    v = '{8'd3, 8'd2, 8'd4, 8'd1};      run_sort(v, "worked");
    v = '{8'd255, 8'd200, 8'd7, 8'd0};  run_sort(v, "reverse");
    v = '{8'd0, 8'd1, 8'd2, 8'd255};    run_sort(v, "ascending");
    v = '{8'd9, 8'd9, 8'd9, 8'd9};      run_sort(v, "R5 all equal");
    v = '{8'd5, 8'd1, 8'd5, 8'd1};      run_sort(v, "R5 pairs");
    for (int t = 0; t < 30; t++) begin
      for (int a = 0; a < K; a++)
        v[a] = (t % 2 == 0) ? W'($urandom) : W'($urandom_range(3, 0));
      run_sort(v, (t % 2 == 0) ? "random" : "R5 random ties");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule